// File: doc/BRIEF.md
# Legacy Memory Segment Access Steering

This block decides, for every host request that falls in the legacy window from 768 KB up to 1 MB, whether the request is claimed for main memory (DRAM) or forwarded to the legacy I/O bus. The window is cut into thirteen segments. Twelve segments of 16 KB cover 0C0000h through 0EFFFFh, and one 64 KB segment covers 0F0000h through 0FFFFFh. Each segment carries a 2-bit attribute with one enable for reads and one for writes. Reads and writes to the same address can therefore take different paths. For example, a segment can be read from the legacy bus while writes land in DRAM, which lets firmware copy code into memory before switching reads over.

Software programs the attributes through a byte-wide configuration port that covers seven attribute registers at consecutive offsets. A lock input freezes the registers. A request outside the window touches no attribute: it is marked pass-through. Every routing decision appears exactly one clock after the request, together with a response valid strobe.

Top module: `legacy_steer`

## Requirements
- R1: After reset every attribute register reads 00h, and every in-window request, read or write, is routed to the legacy bus.
- R2: Within an attribute field, bit 0 enables reads to DRAM and bit 1 enables writes to DRAM. Encoding 00 sends both directions to the legacy bus, 01 sends only reads to DRAM, 10 sends only writes to DRAM, and 11 sends both to DRAM.
- R3: The registers at offsets 81h through 86h each control two consecutive 16 KB segments. Bits 1:0 control the lower segment and bits 5:4 the upper one. Offset 81h covers 0C0000h–0C7FFFh, and each following offset covers the next 32 KB, up to 86h for 0E8000h–0EFFFFh.
- R4: Bits 5:4 of the register at offset 80h control the whole 64 KB segment 0F0000h–0FFFFFh.
- R5: Reserved bits read as zero and ignore writes. These are bits 7:6 and 3:2 of offsets 81h–86h, and bits 7:6 and 3:0 of offset 80h.
- R6: While the lock input is high, configuration writes leave all attribute registers unchanged. Routing continues to use the stored values.
- R7: A configuration write to an offset outside 80h–86h changes no register. A read at such an offset returns 00h.
- R8: A request whose address is below 0C0000h or at or above 100000h raises only the pass-through flag.
- R9: A valid request produces a response strobe exactly one clock later. No response appears without a request. A request that arrives in the same cycle as a configuration write uses the attribute value from before that write.
- R10: On every response strobe exactly one of the DRAM, legacy and pass-through flags is high. All three are low when there is no strobe.
- R11: The configuration read data reflects the register selected by the current configuration address, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| cfg_lock | input | 1 | Blocks attribute writes while high |
| req_valid | input | 1 | Host request valid |
| req_addr | input | HADDR_W | Host request address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_dram | output | 1 | Request claimed for DRAM |
| rsp_legacy | output | 1 | Request forwarded to the legacy bus |
| rsp_pass | output | 1 | Request lies outside the legacy window |

## Verification
Several properties are checked on every cycle. These cover the one-cycle strobe timing, the mutual exclusion of the three routing flags, the pass-through of out-of-window addresses, the zero reserved bits in storage, and the frozen bank while the lock is high. Other behaviour can only be shown by the bench's scenarios, which compare the design against a behavioural model every clock. Those scenarios cover the mapping of each 16 KB and 64 KB segment to its register field, the four encodings in both directions, the dropped writes at stray offsets, and the ordering of a same-cycle write and request.

// File: rtl/legacy_steer_pkg.sv
package legacy_steer_pkg;

   localparam int unsigned REG_W   = 8;
   localparam int unsigned ATTR_W  = 2;
   localparam int unsigned HI_LSB  = 4;
   localparam int unsigned WIN_LO  = 32'h000C_0000;
   localparam int unsigned WIN_TOP = 32'h0010_0000;
   localparam int unsigned BIG_LO  = 32'h000F_0000;

   typedef struct packed {
      logic we;
      logic re;
   } attr_t;

   typedef struct packed {
      logic dram;
      logic legacy;
      logic pass;
   } route_t;

   // writable bits of attribute register idx (0 holds only the 64 KB field)
   function automatic logic [REG_W-1:0] live_mask(input int unsigned idx);
      return (idx == 0) ? 8'h30 : 8'h33;
   endfunction

   function automatic route_t steer(input attr_t a, input logic is_wr, input logic in_win);
      route_t r;
      logic   claim;
      claim    = is_wr ? a.we : a.re;
      r.pass   = !in_win;
      r.dram   = in_win && claim;
      r.legacy = in_win && !claim;
      return r;
   endfunction

endpackage

// File: rtl/attr_bank.sv
module attr_bank
   import legacy_steer_pkg::*;
#(
   parameter int unsigned NUM_REGS = 7,
   parameter int unsigned CFG_AW   = 8,
   parameter logic [CFG_AW-1:0] BANK_BASE = 'h80
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [CFG_AW-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   input  logic                      lock,
   output logic [REG_W-1:0]          rdata,
   output logic [NUM_REGS*REG_W-1:0] bank_flat
);

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [CFG_AW-1:0] OFF  = CFG_AW'(BANK_BASE + gi);
      localparam logic [REG_W-1:0]  MASK = live_mask(gi);
      logic [REG_W-1:0] store_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store_q <= '0;
         end else if (wr_en && !lock && (addr == OFF)) begin
            store_q <= wdata & MASK;
         end
      end

      assign bank_flat[gi*REG_W +: REG_W] = store_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == CFG_AW'(BANK_BASE + i)) begin
            rdata = bank_flat[i*REG_W +: REG_W];
         end
      end
   end

endmodule

// File: rtl/seg_decode.sv
module seg_decode
   import legacy_steer_pkg::*;
#(
   parameter int unsigned HADDR_W  = 32,
   parameter int unsigned NUM_REGS = 7,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [HADDR_W-1:0] addr,
   output logic               in_win,
   output logic [IDX_W-1:0]   reg_idx,
   output logic               hi_half
);

   localparam logic [HADDR_W-1:0] LO  = HADDR_W'(WIN_LO);
   localparam logic [HADDR_W-1:0] TOP = HADDR_W'(WIN_TOP);
   localparam logic [HADDR_W-1:0] BIG = HADDR_W'(BIG_LO);

   logic       in_big;
   logic [3:0] small_idx;

   always_comb begin
      in_win    = (addr >= LO) && (addr < TOP);
      in_big    = (addr >= BIG);
      small_idx = addr[17:14];
      if (in_big) begin
         reg_idx = '0;
         hi_half = 1'b1;
      end else begin
         reg_idx = IDX_W'(small_idx[3:1]) + IDX_W'(1);
         hi_half = small_idx[0];
      end
   end

endmodule

// File: rtl/route_stage.sv
module route_stage
   import legacy_steer_pkg::*;
#(
   parameter int unsigned NUM_REGS = 7,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic                      in_win,
   input  logic [IDX_W-1:0]          reg_idx,
   input  logic                      hi_half,
   input  logic [NUM_REGS*REG_W-1:0] bank_flat,
   output logic                      rsp_valid,
   output route_t                    rsp_route
);

   attr_t  sel_attr;
   route_t next_route;

   always_comb begin
      sel_attr = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (reg_idx == IDX_W'(i)) begin
            sel_attr = hi_half ? bank_flat[i*REG_W+HI_LSB +: ATTR_W]
                               : bank_flat[i*REG_W +: ATTR_W];
         end
      end
      next_route = steer(sel_attr, req_write, in_win);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_route <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_route <= req_valid ? next_route : '0;
      end
   end

endmodule

// File: rtl/legacy_steer.sv
module legacy_steer
   import legacy_steer_pkg::*;
#(
   parameter int unsigned HADDR_W  = 32,
   parameter int unsigned CFG_AW   = 8,
   parameter int unsigned NUM_REGS = 7,
   parameter logic [CFG_AW-1:0] BANK_BASE = 'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic               cfg_lock,
   input  logic               req_valid,
   input  logic [HADDR_W-1:0] req_addr,
   input  logic               req_write,
   output logic               rsp_valid,
   output logic               rsp_dram,
   output logic               rsp_legacy,
   output logic               rsp_pass
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS != 7) begin : g_bad_regs
      $error("legacy_steer: segment map needs exactly seven attribute registers");
   end
   if (HADDR_W < 21) begin : g_bad_addr
      $error("legacy_steer: host address must reach beyond 1 MB");
   end
   if (int'(BANK_BASE) + NUM_REGS > (1 << CFG_AW)) begin : g_bad_base
      $error("legacy_steer: register bank does not fit the configuration space");
   end

   logic [NUM_REGS*REG_W-1:0] bank_flat;
   logic                      in_win;
   logic [IDX_W-1:0]          reg_idx;
   logic                      hi_half;
   route_t                    rsp_route;

   attr_bank #(
      .NUM_REGS (NUM_REGS),
      .CFG_AW   (CFG_AW),
      .BANK_BASE(BANK_BASE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .lock     (cfg_lock),
      .rdata    (cfg_rdata),
      .bank_flat(bank_flat)
   );

   seg_decode #(
      .HADDR_W (HADDR_W),
      .NUM_REGS(NUM_REGS)
   ) u_dec (
      .addr   (req_addr),
      .in_win (in_win),
      .reg_idx(reg_idx),
      .hi_half(hi_half)
   );

   route_stage #(
      .NUM_REGS(NUM_REGS)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .in_win   (in_win),
      .reg_idx  (reg_idx),
      .hi_half  (hi_half),
      .bank_flat(bank_flat),
      .rsp_valid(rsp_valid),
      .rsp_route(rsp_route)
   );

   assign rsp_dram   = rsp_route.dram;
   assign rsp_legacy = rsp_route.legacy;
   assign rsp_pass   = rsp_route.pass;

endmodule

// File: rtl/legacy_steer_chk.sv
module legacy_steer_chk
   import legacy_steer_pkg::*;
#(
   parameter int unsigned HADDR_W  = 32,
   parameter int unsigned NUM_REGS = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_lock,
   input logic                      req_valid,
   input logic [HADDR_W-1:0]        req_addr,
   input logic                      rsp_valid,
   input logic                      rsp_dram,
   input logic                      rsp_legacy,
   input logic                      rsp_pass,
   input logic [NUM_REGS*REG_W-1:0] bank_flat
);

   logic [NUM_REGS*REG_W-1:0] resv_bits;
   logic                      outside;

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         resv_bits[i*REG_W +: REG_W] = (i == 0) ? 8'hCF : 8'hCC;
      end
      outside = (req_addr < HADDR_W'(32'h000C_0000)) || (req_addr > HADDR_W'(32'h000F_FFFF));
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bank_flat == '0));

   p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_flat & resv_bits) == '0);

   p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> $stable(bank_flat));

   p_outside_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && outside) |=> (rsp_valid && rsp_pass));

   p_strobe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_one_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_dram, rsp_legacy, rsp_pass}) == 1));

   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_dram || rsp_legacy || rsp_pass));

endmodule

bind legacy_steer legacy_steer_chk #(
   .HADDR_W (HADDR_W),
   .NUM_REGS(NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_lock  (cfg_lock),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_dram  (rsp_dram),
   .rsp_legacy(rsp_legacy),
   .rsp_pass  (rsp_pass),
   .bank_flat (bank_flat)
);

// File: tb/legacy_steer_test.sv
module legacy_steer_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [7:0]  cfg_addr;
   logic [7:0]  cfg_wdata;
   logic [7:0]  cfg_rdata;
   logic        cfg_lock;
   logic        req_valid;
   logic [31:0] req_addr;
   logic        req_write;
   logic        rsp_valid, rsp_dram, rsp_legacy, rsp_pass;

   always #4 clk = ~clk;   // 125 MHz

   legacy_steer uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_lock(cfg_lock),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_dram(rsp_dram), .rsp_legacy(rsp_legacy),
      .rsp_pass(rsp_pass)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   string tag    = "R1";
   bit    done   = 0;

   // behavioural reference: seven attribute bytes and one pending response
   int m_reg [7];
   bit e_v, e_d, e_l, e_p;

   function automatic int field_of(input logic [31:0] a);
      int seg;
      if (a >= 32'hF0000) return (m_reg[0] >> 4) & 3;
      seg = int'((a - 32'hC0000) / 32'h4000);
      return (m_reg[1 + seg / 2] >> ((seg % 2) * 4)) & 3;
   endfunction

   function automatic int exp_rdata(input logic [7:0] a);
      if (a >= 8'h80 && a <= 8'h86) return m_reg[a - 8'h80];
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_reg[i]) m_reg[i] = 0;
         {e_v, e_d, e_l, e_p} = '0;
      end else begin
         {e_v, e_d, e_l, e_p} = '0;
         if (req_valid) begin
            e_v = 1;
            if (req_addr < 32'hC0000 || req_addr >= 32'h100000) e_p = 1;
            else begin
               int f;
               f = field_of(req_addr);
               e_d = req_write ? f[1] : f[0];
               e_l = !e_d;
            end
         end
         if (cfg_wr_en && !cfg_lock && cfg_addr >= 8'h80 && cfg_addr <= 8'h86)
            m_reg[cfg_addr - 8'h80] = cfg_wdata & ((cfg_addr == 8'h80) ? 8'h30 : 8'h33);
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_chk++;
         if ({rsp_valid, rsp_dram, rsp_legacy, rsp_pass} != {e_v, e_d, e_l, e_p}) begin
            n_fail++;
            $display("FAIL %s route: got v/d/l/p=%b expected %b", tag,
                     {rsp_valid, rsp_dram, rsp_legacy, rsp_pass}, {e_v, e_d, e_l, e_p});
         end
         n_chk++;
         if (int'(cfg_rdata) != exp_rdata(cfg_addr)) begin
            n_fail++;
            $display("FAIL %s rdata at %h: got %h expected %h", tag, cfg_addr,
                     cfg_rdata, exp_rdata(cfg_addr));
         end
      end
   end

   task automatic summary();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
      cyc();
      cfg_wr_en = 0;
   endtask

   task automatic rq(input logic [31:0] a, input logic w);
      req_valid = 1; req_addr = a; req_write = w;
      cyc();
      req_valid = 0;
   endtask

   task automatic sweep();
      for (int s = 0; s < 13; s++) begin
         logic [31:0] base;
         base = (s == 12) ? 32'hF0000 : 32'hC0000 + 32'(s) * 32'h4000;
         rq(base, 0);
         rq(base, 1);
         rq(base + ((s == 12) ? 32'hFFFF : 32'h3FFF), 0);
         rq(base + ((s == 12) ? 32'hFFFF : 32'h3FFF), 1);
      end
   endtask

   initial begin
      rst_n = 0; cfg_wr_en = 0; cfg_addr = 8'h80; cfg_wdata = 0; cfg_lock = 0;
      req_valid = 0; req_addr = 0; req_write = 0;
      repeat (3) cyc();
      rst_n = 1;
      cyc();

      // R1: all registers zero, everything to the legacy bus
      tag = "R1";
      for (int a = 8'h80; a <= 8'h86; a++) begin cfg_addr = 8'(a); cyc(); end
      sweep();

      // R2: four encodings on the lowest segment, both directions
      tag = "R2";
      for (int e = 0; e < 4; e++) begin
         wr(8'h81, 8'(e));
         rq(32'hC0000, 0);
         rq(32'hC1234, 1);
      end

      // R3: distinct patterns per 16 KB segment
      tag = "R3";
      wr(8'h81, 8'h21); wr(8'h82, 8'h12); wr(8'h83, 8'h30);
      wr(8'h84, 8'h03); wr(8'h85, 8'h31); wr(8'h86, 8'h02);
      sweep();

      // R4: 64 KB top segment
      tag = "R4";
      for (int e = 0; e < 4; e++) begin
         wr(8'h80, 8'(e << 4));
         rq(32'hF0000, 0); rq(32'hF8000, 1); rq(32'hFFFFF, 0); rq(32'hEFFFF, 1);
      end

      // R5: reserved bits
      tag = "R5";
      for (int a = 8'h80; a <= 8'h86; a++) wr(8'(a), 8'hFF);
      wr(8'h80, 8'h0F);
      cyc();
      sweep();

      // R6: lock
      tag = "R6";
      cfg_lock = 1;
      for (int a = 8'h80; a <= 8'h86; a++) wr(8'(a), 8'h00);
      cfg_addr = 8'h83; cyc();
      sweep();
      cfg_lock = 0;
      wr(8'h83, 8'h10);
      rq(32'hCC000, 0); rq(32'hD4000, 1);

      // R7: stray offsets
      tag = "R7";
      wr(8'h7F, 8'h33); wr(8'h87, 8'h33); wr(8'h00, 8'hFF); wr(8'hFF, 8'hFF);
      cfg_addr = 8'h87; cyc();
      cfg_addr = 8'h7F; cyc();
      sweep();

      // R8: outside the window
      tag = "R8";
      rq(32'hBFFFF, 0); rq(32'h100000, 1); rq(32'hFFFF_FFFF, 0); rq(32'h0, 1);
      rq(32'h10C0000, 0);

      // R9: idle gaps, back to back, same-cycle write and request
      tag = "R9";
      repeat (3) cyc();
      wr(8'h81, 8'h00);
      cfg_wr_en = 1; cfg_addr = 8'h81; cfg_wdata = 8'h33;
      req_valid = 1; req_addr = 32'hC0000; req_write = 0;
      cyc();
      cfg_wr_en = 0;
      req_addr = 32'hC0000;
      cyc();
      req_valid = 0;
      cyc();

      // R10 and R11: random traffic, config address changes every cycle
      tag = "R10";
      for (int k = 0; k < 3000; k++) begin
         cfg_lock  = ($urandom % 8) == 0;
         cfg_wr_en = ($urandom % 4) == 0;
         cfg_addr  = 8'h7E + 8'($urandom % 10);
         cfg_wdata = 8'($urandom);
         req_valid = ($urandom % 3) != 0;
         req_write = 1'($urandom);
         req_addr  = ($urandom % 8 == 0) ? 32'($urandom) : 32'hBC000 + 32'($urandom % 32'h48000);
         if (k == 1500) tag = "R11";
         cyc();
      end
      cfg_wr_en = 0; req_valid = 0; cfg_lock = 0;
      repeat (2) cyc();
      summary();
   end

endmodule